// File: doc/BRIEF.md
# Dual-Channel Timer Capture/Compare Unit

This block pairs a 16-bit free-running counter with two input capture channels and one output compare channel, all reached through a small 8-bit register bus. Each capture channel watches an external pin through a two-flop synchronizer and an edge detector. When a qualifying edge arrives, the channel stores the counter value into a 16-bit read-only register, which software reads as a high byte and a low byte. Channel one can be set to capture on either edge. Channel two captures on falling edges only.

A status byte holds one event flag for each channel and one for the compare match. A flag is cleared only by a two-step software sequence. First the status byte is read while that flag is set. Then the matching channel's low-byte register is read. The single interrupt output combines the flags, gated by two enables: one enable is shared by both capture channels, and the other belongs to the compare flag. The bus read data is combinational from the address. Read side effects take place at the clock edge on which the read strobe is sampled.

Top module: `tcc_timer`

## Requirements
- R1: After reset the counter is 0. It then increments by one on every clock edge, wrapping modulo 2^16. It reads as high byte at 0x18 and low byte at 0x19.
- R2: A capture stores the counter value of the cycle in which the synchronized edge is detected. That is the count two clocks after the pin change settles ahead of an edge. Channel one reads at 0x14 (high) and 0x15 (low); channel two reads at 0x1C (high) and 0x1D (low).
- R3: Control bit 1 at 0x12 picks channel one's edge: 1 selects rising and 0 selects falling (the reset value). The opposite edge neither captures nor sets a flag.
- R4: Channel two captures on falling edges only. A rising edge on its pin has no effect.
- R5: The compare register is readable and writable at 0x1E (high) and 0x1F (low), and resets to 0xFFFF. The compare flag sets on the clock edge where the counter steps onto the compare value.
- R6: The status byte at 0x13 shows channel one in bit 7, compare in bit 6 and channel two in bit 4. The other bits read 0. A flag clears only when a status read made while it was set is followed by a read of its low byte (0x15, 0x1D, 0x1F). A low-byte read alone leaves the flag set.
- R7: The interrupt output is high when control bit 7 (shared capture enable) is set and either capture flag is set, or when control bit 6 (compare enable) is set and the compare flag is set.
- R8: An event that arrives after the status read and before the low-byte read leaves its flag set.
- R9: If a capture and a read of that channel's low byte fall on the same clock edge, the flag stays set and the new value is stored.
- R10: The compare flag is raised once per counter step onto the match value. After it is cleared, it stays clear while the counter moves on.
- R11: After reset the control byte, all flags and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Register address |
| bus_rd | input | 1 | Read strobe; side effects at the sampling edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cap_pin_a | input | 1 | Capture channel one pin (asynchronous) |
| cap_pin_b | input | 1 | Capture channel two pin (asynchronous) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at the clear sequence. It checks that a low-byte read without a prior status read leaves the flag set, since a design that dropped the arming step would clear it early. It also checks that an event landing between the two reads survives, where a design that arms on every status read would lose it. It lines a low-byte read up on the exact capture edge, where a clear-first priority would drop the flag. It times captured values against an independent cycle count, so an extra or missing synchronizer stage shows up as an off-by-one value. It brackets the compare flag to the exact counter step and then watches that it does not come back.

// File: rtl/tcc_pkg.sv
// Package: shared widths, register offsets and bit positions of the
// capture/compare unit. Assumes an 8-bit data bus and a 16-bit counter.
package tcc_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int NUM_CAP = 2;
    localparam int NUM_EV  = 3;

    // event indices into the flag vector
    localparam int EV_CAP1 = 0;
    localparam int EV_CAP2 = 1;
    localparam int EV_CMP  = 2;

    // register offsets
    localparam logic [ADDR_W-1:0] A_CTRL    = 5'h12;
    localparam logic [ADDR_W-1:0] A_STAT    = 5'h13;
    localparam logic [ADDR_W-1:0] A_CAP1_HI = 5'h14;
    localparam logic [ADDR_W-1:0] A_CAP1_LO = 5'h15;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 5'h18;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 5'h19;
    localparam logic [ADDR_W-1:0] A_CAP2_HI = 5'h1C;
    localparam logic [ADDR_W-1:0] A_CAP2_LO = 5'h1D;
    localparam logic [ADDR_W-1:0] A_CMP_HI  = 5'h1E;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 5'h1F;

    // control bit positions
    localparam int CTRL_CAP_IE = 7;
    localparam int CTRL_CMP_IE = 6;
    localparam int CTRL_RISE1  = 1;

    // status bit positions
    localparam int STAT_CAP1 = 7;
    localparam int STAT_CMP  = 6;
    localparam int STAT_CAP2 = 4;
endpackage

// File: rtl/tcc_capture_ch.sv
// Capture channel: synchronizes an asynchronous pin, detects the selected
// edge and stores the counter value of the detection cycle.
// Assumes the pin idles high; the stored value has no reset (undefined
// until the first capture).
module tcc_capture_ch #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             rise_sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cap_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise_w;
    logic                   fall_w;
    logic [CNT_W-1:0]       cap_q;

    // synchronizer chain plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[LAST-1:0], pin_i};
            last_q <= sync_q[LAST];
        end
    end

    // edge decode and selection
    always_comb begin
        rise_w = sync_q[LAST] & ~last_q;
        fall_w = ~sync_q[LAST] & last_q;
        hit_o  = rise_sel_i ? rise_w : fall_w;
    end

    // capture storage, intentionally without reset
    always_ff @(posedge clk) begin
        if (hit_o) begin
            cap_q <= cnt_i;
        end
    end

    assign cap_o = cap_q;

    p_capture_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (cap_o == $past(cnt_i)))
        else $error("capture value differs from detection-cycle count");

    p_one_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o)
        else $error("edge reported in two consecutive cycles");
endmodule

// File: rtl/tcc_event_flag.sv
// Event flag with a two-step clear. A status read arms the clear only if
// the flag is already set; the next low-byte read then clears it. A new
// event always wins and disarms any pending clear.
// Assumes the status read and the low-byte read never share a cycle.
module tcc_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic low_rd_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;

    // flag and arm state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (set_i) begin
                flag_q <= 1'b1;
            end else if (low_rd_i && armed_q) begin
                flag_q <= 1'b0;
            end
            if (set_i) begin
                armed_q <= 1'b0;
            end else if (stat_rd_i) begin
                armed_q <= flag_q;
            end else if (low_rd_i) begin
                armed_q <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o)
        else $error("event lost");

    p_clear_by_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(low_rd_i))
        else $error("flag cleared without low-byte read");

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !low_rd_i) |=> $stable(flag_o))
        else $error("flag changed without cause");
endmodule

// File: rtl/tcc_compare.sv
// Output compare register and match detection. The match is evaluated
// against the counter's next value, so the event coincides with the
// counter stepping onto the compare value (once per step).
// Assumes the counter advances on every clock.
module tcc_compare #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              hit_o
);
    logic [CNT_W-1:0] cmp_q;

    // byte-wise compare register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else begin
            if (wr_hi_i) cmp_q[CNT_W-1:DATA_W] <= wdata_i;
            if (wr_lo_i) cmp_q[DATA_W-1:0]     <= wdata_i;
        end
    end

    // match on the value the counter is about to take
    always_comb begin
        hit_o = ((cnt_i + CNT_W'(1)) == cmp_q);
    end

    assign cmp_o = cmp_q;

    p_cmp_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> (cmp_o[DATA_W-1:0] == $past(wdata_i)))
        else $error("compare low byte write lost");
endmodule

// File: rtl/tcc_timer.sv
// Capture/compare unit top: free-running counter, two capture channels,
// one compare channel, three event flags, register decode and interrupt.
// Assumes a single-master 8-bit bus with read and write never together.
module tcc_timer
    import tcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_pin_a,
    input  logic              cap_pin_b,
    output logic              irq
);
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [NUM_CAP-1:0] pins_w;
    logic [NUM_CAP-1:0] rise_sel_w;
    logic [NUM_CAP-1:0] cap_hit_w;
    logic [CNT_W-1:0]  cap_val_w [NUM_CAP];
    logic [CNT_W-1:0]  cmp_val_w;
    logic              cmp_hit_w;
    logic [NUM_EV-1:0] ev_set_w;
    logic [NUM_EV-1:0] low_rd_w;
    logic [NUM_EV-1:0] flag_w;
    logic              stat_rd_w;
    logic [DATA_W-1:0] stat_w;

    // free-running counter
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl_q <= '0;
        else if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata;
    end

    // channel pin and edge-select routing; channel two is falling-only
    always_comb begin
        pins_w     = {cap_pin_b, cap_pin_a};
        rise_sel_w = {1'b0, ctrl_q[CTRL_RISE1]};
    end

    for (genvar gi = 0; gi < NUM_CAP; gi++) begin : g_cap
        tcc_capture_ch #(
            .CNT_W       (CNT_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (pins_w[gi]),
            .rise_sel_i (rise_sel_w[gi]),
            .cnt_i      (cnt_q),
            .hit_o      (cap_hit_w[gi]),
            .cap_o      (cap_val_w[gi])
        );
    end

    tcc_compare #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi_i (bus_wr && bus_addr == A_CMP_HI),
        .wr_lo_i (bus_wr && bus_addr == A_CMP_LO),
        .wdata_i (bus_wdata),
        .cnt_i   (cnt_q),
        .cmp_o   (cmp_val_w),
        .hit_o   (cmp_hit_w)
    );

    // event and clear-strobe routing per flag
    always_comb begin
        stat_rd_w          = bus_rd && (bus_addr == A_STAT);
        ev_set_w[EV_CAP1]  = cap_hit_w[0];
        ev_set_w[EV_CAP2]  = cap_hit_w[1];
        ev_set_w[EV_CMP]   = cmp_hit_w;
        low_rd_w[EV_CAP1]  = bus_rd && (bus_addr == A_CAP1_LO);
        low_rd_w[EV_CAP2]  = bus_rd && (bus_addr == A_CAP2_LO);
        low_rd_w[EV_CMP]   = bus_rd && (bus_addr == A_CMP_LO);
    end

    for (genvar gf = 0; gf < NUM_EV; gf++) begin : g_flag
        tcc_event_flag u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (ev_set_w[gf]),
            .stat_rd_i (stat_rd_w),
            .low_rd_i  (low_rd_w[gf]),
            .flag_o    (flag_w[gf])
        );
    end

    // status byte assembly
    always_comb begin
        stat_w            = '0;
        stat_w[STAT_CAP1] = flag_w[EV_CAP1];
        stat_w[STAT_CAP2] = flag_w[EV_CAP2];
        stat_w[STAT_CMP]  = flag_w[EV_CMP];
    end

    // read data multiplexer
    always_comb begin
        case (bus_addr)
            A_CTRL:    bus_rdata = ctrl_q;
            A_STAT:    bus_rdata = stat_w;
            A_CAP1_HI: bus_rdata = cap_val_w[0][CNT_W-1:DATA_W];
            A_CAP1_LO: bus_rdata = cap_val_w[0][DATA_W-1:0];
            A_CNT_HI:  bus_rdata = cnt_q[CNT_W-1:DATA_W];
            A_CNT_LO:  bus_rdata = cnt_q[DATA_W-1:0];
            A_CAP2_HI: bus_rdata = cap_val_w[1][CNT_W-1:DATA_W];
            A_CAP2_LO: bus_rdata = cap_val_w[1][DATA_W-1:0];
            A_CMP_HI:  bus_rdata = cmp_val_w[CNT_W-1:DATA_W];
            A_CMP_LO:  bus_rdata = cmp_val_w[DATA_W-1:0];
            default:   bus_rdata = '0;
        endcase
    end

    // interrupt combination
    always_comb begin
        irq = (ctrl_q[CTRL_CAP_IE] && (flag_w[EV_CAP1] || flag_w[EV_CAP2]))
           || (ctrl_q[CTRL_CMP_IE] && flag_w[EV_CMP]);
    end

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)))
        else $error("counter skipped");

    p_cmp_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_w[EV_CMP]) |-> (($past(cnt_q) + CNT_W'(1)) == $past(cmp_val_w)))
        else $error("compare flag without match");

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTRL_CAP_IE] && !ctrl_q[CTRL_CMP_IE]) |-> !irq)
        else $error("interrupt with both enables clear");

    p_irq_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_CAP_IE] && flag_w[EV_CAP2]) |-> irq)
        else $error("enabled capture flag without interrupt");
endmodule

// File: tb/tcc_timer_tb.sv
module tcc_timer_tb;
    import tcc_pkg::*;

    typedef struct {
        int          ch;
        logic [15:0] val;
    } cap_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_rd = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic cap_pin_a = 1'b1;
    logic cap_pin_b = 1'b1;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] tb_cnt;
    cap_item_t exp_q[$];
    logic [15:0] last_cap [2];

    always #5 clk = ~clk;

    tcc_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin_a(cap_pin_a), .cap_pin_b(cap_pin_b), .irq(irq)
    );

    // reference count: zero in reset, plus one per clock (R1)
    always @(posedge clk) begin
        if (!rst_n) tb_cnt <= 16'd0;
        else        tb_cnt <= tb_cnt + 16'd1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: set a pin level; push expected capture when one is due
    task automatic drive_pin(input int ch, input logic lvl, input logic due);
        cap_item_t it;
        if (ch == 0) cap_pin_a = lvl;
        else         cap_pin_b = lvl;
        if (due) begin
            it.ch  = ch;
            it.val = tb_cnt + 16'd2;
            exp_q.push_back(it);
        end
    endtask

    // monitor: read capture (high then low) and compare to the queue head
    task automatic check_cap(input int ch, input string req);
        logic [7:0] hi;
        logic [7:0] lo;
        cap_item_t it;
        bus_read(ch == 0 ? A_CAP1_HI : A_CAP2_HI, hi);
        bus_read(ch == 0 ? A_CAP1_LO : A_CAP2_LO, lo);
        if (exp_q.size() == 0) begin
            chk({req, " queue empty"}, 1, 0);
        end else begin
            it = exp_q.pop_front();
            chk({req, " channel"}, ch, it.ch);
            chk({req, " captured value"}, {hi, lo}, it.val);
            last_cap[ch] = it.val;
        end
    endtask

    task automatic check_same(input int ch, input string req);
        logic [7:0] hi;
        logic [7:0] lo;
        bus_read(ch == 0 ? A_CAP1_HI : A_CAP2_HI, hi);
        bus_read(ch == 0 ? A_CAP1_LO : A_CAP2_LO, lo);
        chk({req, " capture unchanged"}, {hi, lo}, last_cap[ch]);
    endtask

    task automatic stat_bit(input int b, input logic exp, input string req);
        logic [7:0] s;
        bus_read(A_STAT, s);
        chk(req, s[b], exp);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] e;
        logic [15:0] t;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        bus_read(A_CTRL, d); chk("R11 control", d, 0);
        bus_read(A_STAT, d); chk("R11 status", d, 0);
        chk("R11 irq", irq, 0);

        // R1 counter readback
        wait_cyc(7);
        e = tb_cnt; bus_read(A_CNT_LO, d); chk("R1 count low", d, e[7:0]);
        e = tb_cnt; bus_read(A_CNT_HI, d); chk("R1 count high", d, e[15:8]);

        // R2/R3 channel one falling edge (default)
        drive_pin(0, 1'b0, 1'b1); wait_cyc(4);
        stat_bit(STAT_CAP1, 1'b1, "R3 falling edge sets flag");
        check_cap(0, "R2 ch1 falling");
        stat_bit(STAT_CAP1, 1'b0, "R6 status+low clears flag");

        // R3 rising edge ignored in falling mode
        drive_pin(0, 1'b1, 1'b0); wait_cyc(4);
        stat_bit(STAT_CAP1, 1'b0, "R3 rising ignored");
        check_same(0, "R3");

        // R3 rising mode
        bus_write(A_CTRL, 8'h02);
        drive_pin(0, 1'b0, 1'b0); wait_cyc(4);
        stat_bit(STAT_CAP1, 1'b0, "R3 falling ignored in rising mode");
        drive_pin(0, 1'b1, 1'b1); wait_cyc(4);
        check_cap(0, "R3 ch1 rising");
        stat_bit(STAT_CAP1, 1'b1, "R6 low read alone keeps flag");
        bus_read(A_CAP1_LO, d);
        stat_bit(STAT_CAP1, 1'b0, "R6 armed clear");

        // R4 channel two
        drive_pin(1, 1'b0, 1'b1); wait_cyc(4);
        stat_bit(STAT_CAP2, 1'b1, "R4 falling sets flag");
        check_cap(1, "R4 ch2 falling");
        drive_pin(1, 1'b1, 1'b0); wait_cyc(4);
        stat_bit(STAT_CAP2, 1'b0, "R4 rising ignored");
        check_same(1, "R4");

        // R7 shared capture enable
        bus_write(A_CTRL, 8'h82);
        chk("R7 irq idle", irq, 0);
        drive_pin(1, 1'b0, 1'b1); wait_cyc(4);
        chk("R7 irq on capture flag", irq, 1);
        bus_write(A_CTRL, 8'h02);
        chk("R7 irq masked", irq, 0);

        // R8 event between the two reads
        bus_read(A_STAT, d);
        check_cap(1, "R8 prep");
        stat_bit(STAT_CAP2, 1'b0, "R8 prep cleared");
        drive_pin(1, 1'b1, 1'b0); wait_cyc(4);
        bus_read(A_STAT, d);
        drive_pin(1, 1'b0, 1'b1); wait_cyc(4);
        check_cap(1, "R8 ch2");
        stat_bit(STAT_CAP2, 1'b1, "R8 late event keeps flag");

        // R9 low read coincident with capture
        drive_pin(1, 1'b1, 1'b0); wait_cyc(4);
        bus_read(A_STAT, d);
        drive_pin(1, 1'b0, 1'b1);
        wait_cyc(2);
        bus_read(A_CAP2_LO, d);
        wait_cyc(2);
        stat_bit(STAT_CAP2, 1'b1, "R9 capture beats clear");
        check_cap(1, "R9 ch2");

        // R5 / R10 compare
        bus_write(A_CTRL, 8'h40);
        t = tb_cnt + 16'd40;
        bus_write(A_CMP_HI, t[15:8]);
        bus_write(A_CMP_LO, t[7:0]);
        bus_read(A_CMP_LO, d); chk("R5 compare readback", d, t[7:0]);
        chk("R5 irq before match", irq, 0);
        while (tb_cnt != t - 16'd1) @(negedge clk);
        stat_bit(STAT_CMP, 1'b0, "R5 flag clear one step before");
        stat_bit(STAT_CMP, 1'b1, "R5 flag on match step");
        chk("R5 compare irq", irq, 1);
        bus_read(A_CMP_LO, d);
        stat_bit(STAT_CMP, 1'b0, "R6 compare cleared");
        wait_cyc(30);
        stat_bit(STAT_CMP, 1'b0, "R10 no retrigger");
        chk("R10 irq stays low", irq, 0);

        summary();
    end
endmodule